// File: doc/BRIEF.md
# Data-Source Sample Filter

This block holds a 64-bit filter mask and decides, for each candidate sample from a statistical profiling sampler, whether the sample is recorded or dropped. Each mask bit belongs to one data-source code. A load sample whose data-source code selects a clear mask bit is dropped while the global data-source filter enable is high. Stores, other operations, and every sample taken while the enable is low are always recorded.

Software writes and reads the mask through a plain register port. The parameter `SUP` marks which of the 64 codes the implementation supports. Bits for unsupported codes are never stored and always read as zero. Samples enter on a valid/ready stream. The decision leaves on a second valid/ready stream one clock after acceptance, and carries the full data-source field with it. The downstream consumer applies back-pressure by holding `dec_ready` low. While it does, the pending decision is held and `smp_ready` falls, so `smp_ready` is `!dec_valid || dec_ready`. A sample is taken on any cycle where `smp_valid` and `smp_ready` are both high.

Top module: `dsrc_sample_filter`

## Requirements
- R1: After reset, `rd_data` equals `SUP` (every supported code passes) and `dec_valid` is 0.
- R2: A cycle with `wr_en` high stores `wr_data & SUP`, and `rd_data` shows the stored value from the next cycle on.
- R3: Bits of `rd_data` at positions where `SUP` is 0 always read 0, whatever was written.
- R4: A load sample (`smp_is_load`=1) taken while `filt_en`=1, whose code selects a mask bit equal to 0, gets `dec_keep`=0.
- R5: A load sample whose code selects a mask bit equal to 1 gets `dec_keep`=1, whatever the value of `filt_en`.
- R6: Every sample taken while `filt_en`=0 gets `dec_keep`=1.
- R7: Every sample with `smp_is_load`=0 gets `dec_keep`=1.
- R8: The code is `smp_src[5:0]`; the upper field bits do not affect the decision and are passed unchanged on `dec_src`.
- R9: A sample taken in cycle t gives `dec_valid`=1 in cycle t+1, carrying that sample's decision.
- R10: While `dec_valid`=1 and `dec_ready`=0, `smp_ready` is 0 and `dec_valid`, `dec_keep` and `dec_src` hold their values.
- R11: A sample taken in the same cycle as a register write is judged by the mask value from before the write, and by `filt_en` as sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | Global data-source filter enable |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 64 | Mask write value |
| rd_data | output | 64 | Current mask value |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready |
| smp_is_load | input | 1 | Sample is a load operation |
| smp_src | input | SRC_W | Data-source field; bits [5:0] are the code |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Decision ready (back-pressure) |
| dec_keep | output | 1 | 1 = record the sample, 0 = drop it |
| dec_src | output | SRC_W | Data-source field of the decided sample |

## Verification
The assertions take as given that `smp_valid` is the only qualifier for the other sample inputs. They also assume that the downstream stream follows valid/ready rules, so a held decision is observed only through `dec_ready`. The stimulus changes every input only between clock edges. It drops `dec_ready` at random in a dedicated phase, so that held decisions and a blocked input are both exercised. The bench never counts on the decision values of samples it presents while `smp_ready` is low. It models acceptance itself and compares every port on every cycle.

// File: rtl/dsrc_filter_pkg.sv
package dsrc_filter_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [NUM_CODES-1:0] dsrc_mask_t;
  typedef logic [CODE_W-1:0]    dsrc_code_t;

  // Record unless the filter is on, the op is a load and its mask bit is clear.
  function automatic logic keep_sample(input dsrc_mask_t mask, input logic en,
                                       input logic is_load, input dsrc_code_t code);
    return !(en && is_load && !mask[code]);
  endfunction
endpackage

// File: rtl/dsrc_mask_reg.sv
module dsrc_mask_reg
  import dsrc_filter_pkg::*;
#(
  parameter dsrc_mask_t SUP = '1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  dsrc_mask_t wr_data,
  output dsrc_mask_t mask_q
);
  // One flop per supported code; unsupported codes are tied to zero.
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_bit
    if (SUP[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)        bit_q <= 1'b1;
        else if (wr_en) bit_q <= wr_data[i];
      end
      assign mask_q[i] = bit_q;
    end else begin : g_zero
      assign mask_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dsrc_decide.sv
module dsrc_decide
  import dsrc_filter_pkg::*;
(
  input  dsrc_mask_t mask,
  input  logic       filt_en,
  input  logic       is_load,
  input  dsrc_code_t code,
  output logic       keep
);
  always_comb keep = keep_sample(mask, filt_en, is_load, code);
endmodule

// File: rtl/dsrc_out_slice.sv
module dsrc_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end
endmodule

// File: rtl/dsrc_sample_filter.sv
module dsrc_sample_filter
  import dsrc_filter_pkg::*;
#(
  parameter logic [63:0] SUP   = 64'h7FFF_FFFF_FFFF_FFF5,
  parameter int          SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             filt_en,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  output logic [63:0]      rd_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             smp_is_load,
  input  logic [SRC_W-1:0] smp_src,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_keep,
  output logic [SRC_W-1:0] dec_src
);
  localparam int PAY_W = SRC_W + 1;

  dsrc_mask_t       mask_q;
  logic             keep_c;
  logic [PAY_W-1:0] pay_in, pay_out;

  dsrc_mask_reg #(.SUP(SUP)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mask_q(mask_q)
  );

  dsrc_decide u_dec (
    .mask(mask_q), .filt_en(filt_en), .is_load(smp_is_load),
    .code(smp_src[CODE_W-1:0]), .keep(keep_c)
  );

  assign pay_in = {keep_c, smp_src};

  dsrc_out_slice #(.W(PAY_W)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(smp_valid), .in_ready(smp_ready), .in_data(pay_in),
    .out_valid(dec_valid), .out_ready(dec_ready), .out_data(pay_out)
  );

  assign rd_data  = mask_q;
  assign dec_keep = pay_out[PAY_W-1];
  assign dec_src  = pay_out[SRC_W-1:0];
endmodule

// File: rtl/dsrc_sample_filter_chk.sv
module dsrc_sample_filter_chk #(
  parameter logic [63:0] SUP   = '1,
  parameter int          SRC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             filt_en,
  input logic             wr_en,
  input logic [63:0]      wr_data,
  input logic [63:0]      rd_data,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             smp_is_load,
  input logic [SRC_W-1:0] smp_src,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic             dec_keep,
  input logic [SRC_W-1:0] dec_src
);
  wire take = smp_valid && smp_ready;

  assert_reset_val_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == SUP) && !dec_valid);

  assert_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & SUP));

  assert_unsup_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~SUP) == 64'd0);

  assert_drop_R4: assert property (@(posedge clk) disable iff (rst)
    take && filt_en && smp_is_load && !rd_data[smp_src[5:0]] |=> !dec_keep);

  assert_pass_bit_R5: assert property (@(posedge clk) disable iff (rst)
    take && rd_data[smp_src[5:0]] |=> dec_keep);

  assert_pass_off_R6: assert property (@(posedge clk) disable iff (rst)
    take && !filt_en |=> dec_keep);

  assert_pass_store_R7: assert property (@(posedge clk) disable iff (rst)
    take && !smp_is_load |=> dec_keep);

  assert_src_pass_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> dec_src == $past(smp_src));

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> dec_valid);

  assert_block_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready |-> !smp_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_keep) && $stable(dec_src));
endmodule

bind dsrc_sample_filter dsrc_sample_filter_chk #(.SUP(SUP), .SRC_W(SRC_W)) chk_i (
  .clk(clk), .rst(rst), .filt_en(filt_en), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_is_load(smp_is_load), .smp_src(smp_src), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .dec_keep(dec_keep), .dec_src(dec_src)
);

// File: tb/dsrc_sample_filter_tb_top.sv
`timescale 1ns/1ps
module dsrc_sample_filter_tb_top;
  localparam logic [63:0] SUP   = 64'h7FFF_FFFF_FFFF_FFF5;
  localparam int          SRC_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rst = 1'b1, filt_en = 1'b0, wr_en = 1'b0;
  logic [63:0]      wr_data = '0, rd_data;
  logic             smp_valid = 1'b0, smp_ready, smp_is_load = 1'b0;
  logic [SRC_W-1:0] smp_src = '0, dec_src;
  logic             dec_valid, dec_ready = 1'b1, dec_keep;

  dsrc_sample_filter #(.SUP(SUP), .SRC_W(SRC_W)) dut_i (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Behavioural reference model.
  logic [63:0]      m_reg = SUP;
  logic             m_vld = 1'b0, m_keep = 1'b0;
  logic [SRC_W-1:0] m_src = '0;
  string            m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= SUP; m_vld <= 1'b0; m_keep <= 1'b0; m_src <= '0; m_tag <= "R1";
    end else begin
      if (wr_en) m_reg <= wr_data & SUP;
      if (!m_vld || dec_ready) begin
        m_vld <= smp_valid;
        if (smp_valid) begin
          m_src  <= smp_src;
          m_keep <= !(filt_en && smp_is_load && !m_reg[smp_src[5:0]]);
          if (!smp_is_load)               m_tag <= "R7";
          else if (m_reg[smp_src[5:0]])   m_tag <= "R5";
          else if (!filt_en)              m_tag <= "R6";
          else                            m_tag <= "R4";
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every port against the model on every clock, between edges.
  always @(negedge clk) if (!done) begin
    chk("R2 R3 rd_data", rd_data, m_reg);
    chk("R9 dec_valid", {63'd0, dec_valid}, {63'd0, m_vld});
    chk("R10 smp_ready", {63'd0, smp_ready}, {63'd0, !m_vld || dec_ready});
    if (m_vld) begin
      chk({m_tag, " dec_keep"}, {63'd0, dec_keep}, {63'd0, m_keep});
      chk("R8 dec_src", {48'd0, dec_src}, {48'd0, m_src});
    end
  end

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic send(input logic ld, input logic [SRC_W-1:0] src);
    smp_valid = 1'b1; smp_is_load = ld; smp_src = src;
    step();
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    chk("R1 reset mask", rd_data, SUP);  // R1
    // R3: all-ones write keeps only supported bits
    wr_en = 1'b1; wr_data = '1; step();
    wr_data = 64'h0; step(); wr_en = 1'b0;
    chk("R3 zero write", rd_data, 64'h0);
    // R4 R8: clear mask, enable, load code 5 with noisy upper bits -> drop
    filt_en = 1'b1;
    send(1'b1, 16'hFFC5);
    chk("R8 drop via low six bits", {63'd0, dec_keep}, 64'd0);
    // R5: set bit 5 only, same code passes
    wr_en = 1'b1; wr_data = 64'h20; step(); wr_en = 1'b0;
    send(1'b1, 16'h0005);
    chk("R5 set bit passes", {63'd0, dec_keep}, 64'd1);
    // R7: store on a clear bit passes
    send(1'b0, 16'h0006);
    chk("R7 store passes", {63'd0, dec_keep}, 64'd1);
    // R6: enable off, load on clear bit passes
    filt_en = 1'b0; send(1'b1, 16'h0006);
    chk("R6 disabled passes", {63'd0, dec_keep}, 64'd1);
    // R11: write that clears bit 5 in same cycle as a load on code 5
    filt_en = 1'b1;
    wr_en = 1'b1; wr_data = 64'h0;
    send(1'b1, 16'h0005);
    wr_en = 1'b0;
    chk("R11 old mask used", {63'd0, dec_keep}, 64'd1);
    send(1'b1, 16'h0005);
    chk("R11 new mask used", {63'd0, dec_keep}, 64'd0);
    // R4 R5 R6 R7 R8: random traffic, sink always ready
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 16) == 0; wr_data = {$urandom, $urandom};
      filt_en = $urandom; smp_valid = $urandom; smp_is_load = $urandom;
      smp_src = $urandom;
      step();
    end
    // R10: random back-pressure
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 16) == 0; wr_data = {$urandom, $urandom};
      filt_en = $urandom; smp_valid = $urandom; smp_is_load = $urandom;
      smp_src = $urandom; dec_ready = ($urandom % 3) != 0;
      step();
    end
    smp_valid = 1'b0; wr_en = 1'b0; dec_ready = 1'b1;
    repeat (3) step();
    summary();
  end
endmodule